// File: doc/BRIEF.md
# Legacy Math-Coprocessor I/O Port Responder

This block answers the sixteen-port I/O window that legacy software uses to talk to a separate math coprocessor. The window begins at I/O address 0xF0. The block models no arithmetic. Its job is to keep the coprocessor error interrupt line (IRQ13) in a sane state and to decode two byte-wide command ports:

- a write to 0xF0 clears the busy latch;
- a write to 0xF1 resets the coprocessor.

Each command produces a one-cycle pulse toward the rest of the chip.

An external error input raises IRQ13, and IRQ13 stays high until software makes a byte write somewhere in the window. Some accesses have no meaning in this model:

- opcode-transfer writes;
- other byte writes outside the two command ports;
- writes wider than a byte;
- reads.

Each of these is reported on an unsupported-access strobe in the same cycle as the access. A read inside the window also drives an all-ones byte onto the read data bus.

Top module: `copro_port_handler`

## Requirements
- R1: While and after synchronous active-low reset, irq13_o, clr_busy_o and copro_rst_o are 0. With no strobe active, unsup_o is 0 and io_rdata is 0x00.
- R2: An access whose address lies outside 0xF0..0xFF (all 16 address bits compared) has no effect. unsup_o stays 0, io_rdata stays 0x00, irq13_o is unchanged and no command pulse appears.
- R3: err_in high at a clock edge makes irq13_o 1 after that edge. irq13_o then holds its value until a clearing write occurs. If err_in and a clearing write fall in the same cycle, err_in wins and irq13_o is 1.
- R4: A byte write (io_size code 0, io_wr=1, io_rd=0) to any address in the window clears irq13_o at the next edge, whichever port it hits.
- R5: A byte write to 0xF0 produces clr_busy_o=1 for exactly the cycle after the write edge, with unsup_o=0.
- R6: A byte write to 0xF1 produces copro_rst_o=1 for exactly the cycle after the write edge, with unsup_o=0.
- R7: A byte write to any other window port (for example 0xF8, 0xFA, 0xFC or 0xFF) raises unsup_o in the cycle of the strobe and produces no command pulse.
- R8: A write in the window with io_size code 1 (16-bit), 2 (32-bit) or 3 raises unsup_o. It leaves irq13_o unchanged and produces no command pulse.
- R9: A read in the window, of any size, raises unsup_o in the strobe cycle and drives io_rdata to 0xFF in that cycle. It leaves irq13_o unchanged.
- R10: An access with io_rd and io_wr both high is handled as a read alone. It raises unsup_o and returns 0xFF, and it neither clears irq13_o nor produces a command pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_size | input | 2 | Access width code: 0 byte, 1 word, 2 dword, 3 reserved |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid in the read strobe cycle |
| err_in | input | 1 | Coprocessor error indication, raises IRQ13 |
| irq13_o | output | 1 | Coprocessor error interrupt request |
| unsup_o | output | 1 | Unsupported-access strobe, aligned with the access strobe |
| clr_busy_o | output | 1 | One-cycle clear-busy command pulse |
| copro_rst_o | output | 1 | One-cycle coprocessor reset command pulse |

## Verification
The results fall into two timing groups:

- unsup_o and io_rdata are combinational, so they are due in the same cycle as the strobe;
- irq13_o, clr_busy_o and copro_rst_o are registered, so they are due one edge later.

The bench drives every input at a falling edge and holds it for one full cycle. It samples one nanosecond after the next rising edge. At that moment the held inputs still select the combinational results, and the registers already show the effect of the access. Each driven cycle therefore pairs with exactly one expected item in the scoreboard queue.

// File: rtl/copro_port_pkg.sv
// Shared types for the coprocessor port responder.
// Assumes: one access per cycle; the size code is meaningful only with a strobe.
package copro_port_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    // Classification of the current cycle's access
    typedef enum logic [2:0] {
        PK_NONE      = 3'd0,
        PK_CLR_BUSY  = 3'd1,
        PK_FPU_RESET = 3'd2,
        PK_OPCODE    = 3'd3,
        PK_WIDE_WR   = 3'd4,
        PK_READ      = 3'd5
    } port_kind_e;

    typedef struct packed {
        logic       hit;      // address inside the window
        logic       byte_wr;  // qualifying byte write (clears IRQ13)
        port_kind_e kind;
    } port_dec_t;

endpackage

// File: rtl/copro_port_decode.sv
// Address-window decoder. It classifies the access present in this cycle.
// Assumes: the window is SPAN consecutive ports from BASE; the two command ports
// sit at offsets CLR_OFS and RST_OFS; a read takes precedence over a write.
module copro_port_decode
    import copro_port_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] BASE    = 16'h00F0,
    parameter int          SPAN    = 16,
    parameter int          CLR_OFS = 0,
    parameter int          RST_OFS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              rd,
    input  logic              wr,
    output port_dec_t         dec
);
    localparam int OFS_W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);
    localparam logic [OFS_W-1:0]  CLR_O  = OFS_W'(CLR_OFS);
    localparam logic [OFS_W-1:0]  RST_O  = OFS_W'(RST_OFS);

    logic [ADDR_W-1:0] diff;
    logic [OFS_W-1:0]  ofs;
    logic              in_win;

    // Purpose: distance from the window base; wrap-around pushes misses above SPAN
    always_comb begin
        diff   = addr - BASE_A;
        ofs    = diff[OFS_W-1:0];
        in_win = (diff < SPAN_A);
    end

    // Purpose: map strobe, size and offset onto one access kind
    always_comb begin
        dec.hit     = in_win;
        dec.byte_wr = 1'b0;
        dec.kind    = PK_NONE;
        if (in_win && rd) begin
            dec.kind = PK_READ;
        end else if (in_win && wr) begin
            if (acc_size_e'(size) != ACC_BYTE) begin
                dec.kind = PK_WIDE_WR;
            end else begin
                dec.byte_wr = 1'b1;
                if (ofs == CLR_O)      dec.kind = PK_CLR_BUSY;
                else if (ofs == RST_O) dec.kind = PK_FPU_RESET;
                else                   dec.kind = PK_OPCODE;
            end
        end
    end

endmodule

// File: rtl/copro_irq_latch.sv
// IRQ13 holding register: set by the error input, cleared by a qualifying write.
// Assumes: set beats clear when both arrive in the same cycle.
module copro_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    // Purpose: hold the interrupt level between set and clear events
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_o <= 1'b0;
        else if (set_i) irq_o <= 1'b1;
        else if (clr_i) irq_o <= 1'b0;
    end

    // R3
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);

    // R4
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o);

    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_o));

endmodule

// File: rtl/copro_cmd_pulse.sv
// Turns a decoded command into a registered one-cycle pulse.
// Assumes: fire_i is high for one cycle per access.
module copro_cmd_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    // Purpose: register the command strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= fire_i;
    end
endmodule

// File: rtl/copro_port_handler.sv
// Top level of the legacy coprocessor port responder. It decodes the window,
// keeps IRQ13, pulses the two commands and flags unsupported accesses.
// Assumes: single-cycle strobes; no write data is consumed by this model.
module copro_port_handler
    import copro_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE      = 16'h00F0,
    parameter int          SPAN      = 16,
    parameter int          RDATA_W   = 8,
    parameter logic [7:0]  READ_FILL = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [1:0]         io_size,
    input  logic               io_rd,
    input  logic               io_wr,
    output logic [RDATA_W-1:0] io_rdata,
    input  logic               err_in,
    output logic               irq13_o,
    output logic               unsup_o,
    output logic               clr_busy_o,
    output logic               copro_rst_o
);
    localparam int CMD_N = 2;
    localparam logic [RDATA_W-1:0] FILL_W = RDATA_W'(READ_FILL);

    port_dec_t        dec;
    logic [CMD_N-1:0] cmd_fire;
    logic [CMD_N-1:0] cmd_pulse;

    copro_port_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .SPAN   (SPAN),
        .CLR_OFS(0),
        .RST_OFS(1)
    ) u_decode (
        .addr(io_addr),
        .size(io_size),
        .rd  (io_rd),
        .wr  (io_wr),
        .dec (dec)
    );

    // Purpose: unsupported strobe and read data, both in the access cycle
    always_comb begin
        unsup_o  = (dec.kind == PK_OPCODE) || (dec.kind == PK_WIDE_WR) ||
                   (dec.kind == PK_READ);
        io_rdata = (dec.kind == PK_READ) ? FILL_W : '0;
    end

    copro_irq_latch u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(err_in),
        .clr_i(dec.byte_wr),
        .irq_o(irq13_o)
    );

    // Purpose: one pulse register per decoded command kind
    for (genvar g = 0; g < CMD_N; g++) begin : g_cmd
        localparam port_kind_e KIND = (g == 0) ? PK_CLR_BUSY : PK_FPU_RESET;
        assign cmd_fire[g] = (dec.kind == KIND);
        copro_cmd_pulse u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire_i (cmd_fire[g]),
            .pulse_o(cmd_pulse[g])
        );
    end

    assign clr_busy_o  = cmd_pulse[0];
    assign copro_rst_o = cmd_pulse[1];

    // R5
    cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_busy_o, copro_rst_o}));

    // R5
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && io_size == 2'd0 && io_addr == ADDR_W'(BASE)) |=> clr_busy_o);

    // R6
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && io_size == 2'd0 && io_addr == ADDR_W'(BASE + 16'd1)) |=> copro_rst_o);

    // R9
    read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && dec.hit) |-> (unsup_o && io_rdata == FILL_W));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !io_wr) |-> (!unsup_o && io_rdata == '0));

    // R10
    rdwr_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_wr && !err_in) |=> $stable(irq13_o));

endmodule

// File: tb/copro_port_handler_tb.sv
// Scoreboard bench: the driver pushes one expected item per cycle and the monitor
// pops and compares it one nanosecond after the following rising edge.
module copro_port_handler_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic        io_rd, io_wr, err_in;
    logic [7:0]  io_rdata;
    logic        irq13_o, unsup_o, clr_busy_o, copro_rst_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic       irq;
        logic       unsup;
        logic       clr;
        logic       crst;
        logic [7:0] rdata;
    } exp_t;

    exp_t exp_q[$];
    logic model_irq = 1'b0;

    always #5 clk = ~clk;

    copro_port_handler u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_size    (io_size),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_rdata   (io_rdata),
        .err_in     (err_in),
        .irq13_o    (irq13_o),
        .unsup_o    (unsup_o),
        .clr_busy_o (clr_busy_o),
        .copro_rst_o(copro_rst_o)
    );

    // Driver: one cycle of stimulus plus the expected item it implies
    task automatic cyc(input string tag, input logic rst, input logic rd, input logic wr,
                       input logic [1:0] sz, input logic [15:0] addr, input logic err);
        exp_t e;
        logic inwin, bytew;
        @(negedge clk);
        rst_n = rst; io_rd = rd; io_wr = wr; io_size = sz; io_addr = addr; err_in = err;
        inwin   = (addr >= 16'h00F0) && (addr <= 16'h00FF);
        bytew   = inwin && wr && !rd && (sz == 2'd0);
        e.tag   = tag;
        e.unsup = inwin && (rd || (wr && (sz != 2'd0 || (addr != 16'h00F0 && addr != 16'h00F1))));
        e.rdata = (inwin && rd) ? 8'hFF : 8'h00;
        e.clr   = rst && bytew && (addr == 16'h00F0);
        e.crst  = rst && bytew && (addr == 16'h00F1);
        if (!rst)      model_irq = 1'b0;
        else if (err)  model_irq = 1'b1;
        else if (bytew) model_irq = 1'b0;
        e.irq   = model_irq;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag, input logic err);
        cyc(tag, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, err);
    endtask

    // Monitor: compare each item after the edge that captures its stimulus
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (irq13_o !== e.irq || unsup_o !== e.unsup || clr_busy_o !== e.clr ||
                    copro_rst_o !== e.crst || io_rdata !== e.rdata)
                begin
                    n_fails++;
                    $display("FAIL %s: actual irq=%b unsup=%b clr=%b rst=%b rdata=%h expected irq=%b unsup=%b clr=%b rst=%b rdata=%h",
                             e.tag, irq13_o, unsup_o, clr_busy_o, copro_rst_o, io_rdata,
                             e.irq, e.unsup, e.clr, e.crst, e.rdata);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0; io_size = 2'd0; io_addr = '0; err_in = 1'b0;
        // R1 reset state, including an error request held off by reset
        cyc("R1 reset", 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0);
        cyc("R1 reset err", 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b1);
        idle("R1 after reset", 1'b0);
        // R3 set and hold
        idle("R3 set", 1'b1);
        idle("R3 hold", 1'b0);
        // R2 outside the window
        cyc("R2 below", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00EF, 1'b0);
        cyc("R2 above", 1'b1, 1'b0, 1'b1, 2'd0, 16'h0100, 1'b0);
        cyc("R2 upper bits", 1'b1, 1'b0, 1'b1, 2'd0, 16'h10F0, 1'b0);
        cyc("R2 read outside", 1'b1, 1'b1, 1'b0, 2'd0, 16'h00EF, 1'b0);
        // R9 reads
        cyc("R9 read F5", 1'b1, 1'b1, 1'b0, 2'd0, 16'h00F5, 1'b0);
        cyc("R9 read F0 dword", 1'b1, 1'b1, 1'b0, 2'd2, 16'h00F0, 1'b0);
        // R8 wide writes
        cyc("R8 word F0", 1'b1, 1'b0, 1'b1, 2'd1, 16'h00F0, 1'b0);
        cyc("R8 dword F1", 1'b1, 1'b0, 1'b1, 2'd2, 16'h00F1, 1'b0);
        cyc("R8 rsvd F8", 1'b1, 1'b0, 1'b1, 2'd3, 16'h00F8, 1'b0);
        // R10 read and write together
        cyc("R10 rdwr F0", 1'b1, 1'b1, 1'b1, 2'd0, 16'h00F0, 1'b0);
        // R4 R5 clear-busy
        cyc("R5 clr busy", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F0, 1'b0);
        idle("R5 pulse ends", 1'b0);
        // R6 reset command
        idle("R3 reset again", 1'b1);
        cyc("R6 copro reset", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F1, 1'b0);
        idle("R6 pulse ends", 1'b0);
        // R7 opcode ports
        idle("R3 set F8", 1'b1);
        cyc("R7 F8", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F8, 1'b0);
        idle("R3 set FA", 1'b1);
        cyc("R7 FA", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00FA, 1'b0);
        cyc("R7 FC low", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00FC, 1'b0);
        idle("R3 set FF", 1'b1);
        cyc("R7 FF", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00FF, 1'b0);
        // R3 error beats a clearing write in the same cycle
        cyc("R3 set wins", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F0, 1'b1);
        // R5 back-to-back clear-busy writes
        cyc("R5 back to back a", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F0, 1'b0);
        cyc("R5 back to back b", 1'b1, 1'b0, 1'b1, 2'd0, 16'h00F0, 1'b0);
        idle("R1 quiet", 1'b0);
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule